// File: doc/BRIEF.md
# UART Buffering and Event Unit

This block sits between a host register port and a serial UART core. It owns the byte storage for both directions and the event logic that tells the host what happened. Received bytes arrive from the serial core together with tags for a missing stop bit and a bad parity bit. They land in a receive queue that the host drains one byte per read. Host writes first enter a four-deep staging queue. That queue drains into a large transmit queue, one byte per cycle, whenever the transmit queue has room. The serial core pops bytes from the transmit queue as it shifts them out.

Occupancy counts and empty/full flags are visible to the host at all times. Twelve event sources feed a sticky status register that the host clears by writing ones. A per-bit mask decides which status bits contribute to the single interrupt line. The receive almost-full event and the transmit almost-empty event are sampled only at the moment of a push or a pop. Each is compared against a threshold register the host can reprogram.

Top module: `serbuf_evt_unit`

## Requirements
- R1: After reset all three counts are 0, the flag word is 7'b0001110, the status and mask registers are 0, `irq` is 0, the almost-full threshold is 192 and the almost-empty threshold is 8.
- R2: A `rx_push` while the receive count is below 256 stores `rx_data` and sets status bit 8. A `host_rd` while the receive count is non-zero removes the oldest byte and presents it on `host_rd_data` from the next cycle. `host_rd_data` holds its value until the next `host_rd`. `rx_count` tracks the number of stored bytes.
- R3: A `rx_push` while the receive count is 256 discards the byte, leaves the count at 256 and sets status bit 4. A read in the same cycle still removes a byte.
- R4: On every `rx_push`, `rx_frame_bad` sets status bit 2 and `rx_parity_bad` sets status bit 3, whether or not the byte is stored.
- R5: A `host_rd` while the receive count is 0 sets status bit 0, loads 0 into `host_rd_data` and changes no count.
- R6: A `host_wr` while the staging count is below 4 stores the byte. A `host_wr` while the staging count is 4 drops the byte and sets status bit 1. Fullness is judged on the count before the edge, even if a byte drains in the same cycle.
- R7: In every cycle where the staging count is non-zero and the transmit count is below 256, the oldest staged byte moves to the transmit queue and status bit 9 is set. `tx_data` shows the oldest transmit byte, or 0 when the queue is empty, and `tx_valid` is high when it is non-empty.
- R8: A `tx_pop` with a non-empty transmit queue removes the oldest byte and sets status bit 7. A `tx_pop` on an empty queue changes nothing.
- R9: On every `rx_push`, status bit 5 is set when the receive count before the edge is greater than or equal to the almost-full threshold.
- R10: On every accepted `tx_pop`, status bit 11 is set when the transmit count before the edge is less than or equal to the almost-empty threshold.
- R11: With `clr_we` high, each status bit whose `clr_bits` bit is 1 is cleared and all others are kept. A hardware set in the same cycle wins over the clear.
- R12: `irq` is the OR of the status bits whose mask bit is 0. Masked events still set their status bits. `mask_we` loads `mask_bits`, and `thr_we` loads both thresholds; the new values apply from the next cycle.
- R13: The flag word is: bit 0 always 0, bit 1 receive empty, bit 2 staging empty, bit 3 transmit empty, bit 4 receive full, bit 5 staging full, bit 6 transmit full.
- R14: `proto_rd_err` sets status bit 10. Status bit 6 is reserved and always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_push | input | 1 | Serial core delivers a received byte |
| rx_data | input | 8 | Received byte |
| rx_frame_bad | input | 1 | Received byte lacked its stop bit |
| rx_parity_bad | input | 1 | Received byte failed parity |
| tx_pop | input | 1 | Serial core takes the oldest transmit byte |
| tx_data | output | 8 | Oldest transmit byte, 0 when empty |
| tx_valid | output | 1 | Transmit queue non-empty |
| host_rd | input | 1 | Host reads one received byte |
| host_rd_data | output | 8 | Byte returned by the last host read |
| host_wr | input | 1 | Host writes one byte for transmission |
| host_wr_data | input | 8 | Byte written by the host |
| proto_rd_err | input | 1 | Protocol-mode read error event |
| clr_we | input | 1 | Write-one-to-clear strobe for status |
| clr_bits | input | 12 | Status bits to clear |
| mask_we | input | 1 | Mask register write strobe |
| mask_bits | input | 12 | New mask value |
| thr_we | input | 1 | Threshold write strobe |
| thr_afull | input | 9 | New receive almost-full threshold |
| thr_aempty | input | 9 | New transmit almost-empty threshold |
| rx_count | output | 9 | Receive queue occupancy |
| tx_count | output | 9 | Transmit queue occupancy |
| wf_count | output | 3 | Staging queue occupancy |
| flags | output | 7 | Empty and full flag word |
| irq_status | output | 12 | Sticky event status |
| irq_mask | output | 12 | Interrupt mask |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is a full staging queue. It needs the transmit queue to hold all 256 bytes first, because the staging queue otherwise drains every cycle. Reaching a receive overflow likewise takes 256 unread pushes. The stimulus therefore starts with directed phases. One pushes past the receive limit and reads past empty. Another writes every cycle with no transmit pops until the host sees dropped writes. After these, seeded random phases with skewed push and pop rates exercise threshold, clear and mask interactions around those extremes.

// File: rtl/serbuf_pkg.sv
package serbuf_pkg;
   localparam int EVT_W        = 12;
   localparam int EV_RD_EMPTY  = 0;
   localparam int EV_WR_FULL   = 1;
   localparam int EV_FRAME     = 2;
   localparam int EV_PARITY    = 3;
   localparam int EV_RX_OVF    = 4;
   localparam int EV_RX_AFULL  = 5;
   localparam int EV_RSVD      = 6;
   localparam int EV_TX_POP    = 7;
   localparam int EV_RX_PUSH   = 8;
   localparam int EV_WF_POP    = 9;
   localparam int EV_PROTO     = 10;
   localparam int EV_TX_AEMPTY = 11;

   localparam int FLAG_W       = 7;
   localparam int FL_RX_EMPTY  = 1;
   localparam int FL_WF_EMPTY  = 2;
   localparam int FL_TX_EMPTY  = 3;
   localparam int FL_RX_FULL   = 4;
   localparam int FL_WF_FULL   = 5;
   localparam int FL_TX_FULL   = 6;
endpackage

// File: rtl/serbuf_fifo.sv
module serbuf_fifo #(
   parameter  int W          = 8,
   parameter  int DEPTH      = 4,
   parameter  int FLOP_LIMIT = 8,
   localparam int AW         = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW         = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  push_data,
   input  logic          pop,
   output logic [W-1:0]  head,
   output logic [CW-1:0] count,
   output logic          empty,
   output logic          full,
   output logic          push_ok,
   output logic          pop_ok
);
   localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

   initial begin
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0)
         $fatal(1, "serbuf_fifo: DEPTH must be a power of two of at least 2");
      if (W < 1)
         $fatal(1, "serbuf_fifo: W must be positive");
   end

   logic [AW-1:0] wr_ptr_q, rd_ptr_q;
   logic [CW-1:0] cnt_q;

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == FULL_C);
   assign push_ok = push & ~full;
   assign pop_ok  = pop & ~empty;
   assign count   = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         cnt_q    <= '0;
      end else begin
         if (push_ok) wr_ptr_q <= wr_ptr_q + 1'b1;
         if (pop_ok)  rd_ptr_q <= rd_ptr_q + 1'b1;
         cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
      end
   end

   generate
      if (DEPTH <= FLOP_LIMIT) begin : g_flops
         logic [W-1:0] slot_q [DEPTH];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
            end else if (push_ok) begin
               slot_q[wr_ptr_q] <= push_data;
            end
         end
         assign head = slot_q[rd_ptr_q];
      end else begin : g_array
         logic [W-1:0] mem [DEPTH];
         always_ff @(posedge clk) begin
            if (push_ok) mem[wr_ptr_q] <= push_data;
         end
         assign head = mem[rd_ptr_q];
      end
   endgenerate
endmodule

// File: rtl/serbuf_irq.sv
module serbuf_irq #(
   parameter int N = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_v,
   input  logic         clr_we,
   input  logic [N-1:0] clr_v,
   input  logic         mask_we,
   input  logic [N-1:0] mask_v,
   output logic [N-1:0] status,
   output logic [N-1:0] mask,
   output logic         irq
);
   initial begin
      if (N < 1) $fatal(1, "serbuf_irq: N must be positive");
   end

   genvar b;
   generate
      for (b = 0; b < N; b++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) status[b] <= 1'b0;
            else        status[b] <= (status[b] & ~(clr_we & clr_v[b])) | set_v[b];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask <= '0;
      else if (mask_we) mask <= mask_v;
   end

   assign irq = |(status & ~mask);
endmodule

// File: rtl/serbuf_evt_unit.sv
module serbuf_evt_unit
   import serbuf_pkg::*;
#(
   parameter  int DATA_W      = 8,
   parameter  int RX_DEPTH    = 256,
   parameter  int TX_DEPTH    = 256,
   parameter  int WF_DEPTH    = 4,
   parameter  int AFULL_INIT  = 192,
   parameter  int AEMPTY_INIT = 8,
   localparam int RXC_W       = $clog2(RX_DEPTH + 1),
   localparam int TXC_W       = $clog2(TX_DEPTH + 1),
   localparam int WFC_W       = $clog2(WF_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_push,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_frame_bad,
   input  logic              rx_parity_bad,
   input  logic              tx_pop,
   output logic [DATA_W-1:0] tx_data,
   output logic              tx_valid,
   input  logic              host_rd,
   output logic [DATA_W-1:0] host_rd_data,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wr_data,
   input  logic              proto_rd_err,
   input  logic              clr_we,
   input  logic [EVT_W-1:0]  clr_bits,
   input  logic              mask_we,
   input  logic [EVT_W-1:0]  mask_bits,
   input  logic              thr_we,
   input  logic [RXC_W-1:0]  thr_afull,
   input  logic [TXC_W-1:0]  thr_aempty,
   output logic [RXC_W-1:0]  rx_count,
   output logic [TXC_W-1:0]  tx_count,
   output logic [WFC_W-1:0]  wf_count,
   output logic [FLAG_W-1:0] flags,
   output logic [EVT_W-1:0]  irq_status,
   output logic [EVT_W-1:0]  irq_mask,
   output logic              irq
);
   initial begin
      if (AFULL_INIT < 0 || AFULL_INIT > RX_DEPTH)
         $fatal(1, "serbuf_evt_unit: AFULL_INIT out of range");
      if (AEMPTY_INIT < 0 || AEMPTY_INIT > TX_DEPTH)
         $fatal(1, "serbuf_evt_unit: AEMPTY_INIT out of range");
   end

   // receive queue
   logic [DATA_W-1:0] rx_head;
   logic rx_empty, rx_full, rx_push_ok, rx_pop_ok;

   serbuf_fifo #(.W(DATA_W), .DEPTH(RX_DEPTH)) rx_q_i (
      .clk(clk), .rst_n(rst_n),
      .push(rx_push), .push_data(rx_data), .pop(host_rd),
      .head(rx_head), .count(rx_count), .empty(rx_empty), .full(rx_full),
      .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
   );

   // staging queue and transmit queue
   logic [DATA_W-1:0] wf_head, tx_head;
   logic wf_empty, wf_full, wf_push_ok, wf_pop_ok;
   logic tx_empty, tx_full, tx_push_ok, tx_pop_ok;
   logic move;

   assign move = ~wf_empty & ~tx_full;

   serbuf_fifo #(.W(DATA_W), .DEPTH(WF_DEPTH)) wf_q_i (
      .clk(clk), .rst_n(rst_n),
      .push(host_wr), .push_data(host_wr_data), .pop(move),
      .head(wf_head), .count(wf_count), .empty(wf_empty), .full(wf_full),
      .push_ok(wf_push_ok), .pop_ok(wf_pop_ok)
   );

   serbuf_fifo #(.W(DATA_W), .DEPTH(TX_DEPTH)) tx_q_i (
      .clk(clk), .rst_n(rst_n),
      .push(move), .push_data(wf_head), .pop(tx_pop),
      .head(tx_head), .count(tx_count), .empty(tx_empty), .full(tx_full),
      .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
   );

   assign tx_data  = tx_empty ? '0 : tx_head;
   assign tx_valid = ~tx_empty;

   // thresholds
   logic [RXC_W-1:0] afull_q;
   logic [TXC_W-1:0] aempty_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         afull_q  <= RXC_W'(AFULL_INIT);
         aempty_q <= TXC_W'(AEMPTY_INIT);
      end else if (thr_we) begin
         afull_q  <= thr_afull;
         aempty_q <= thr_aempty;
      end
   end

   // host read data register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       host_rd_data <= '0;
      else if (host_rd) host_rd_data <= rx_pop_ok ? rx_head : '0;
   end

   // event vector
   logic [EVT_W-1:0] ev;

   always_comb begin
      ev               = '0;
      ev[EV_RD_EMPTY]  = host_rd & ~rx_pop_ok;
      ev[EV_WR_FULL]   = host_wr & ~wf_push_ok;
      ev[EV_FRAME]     = rx_push & rx_frame_bad;
      ev[EV_PARITY]    = rx_push & rx_parity_bad;
      ev[EV_RX_OVF]    = rx_push & ~rx_push_ok;
      ev[EV_RX_AFULL]  = rx_push & (rx_count >= afull_q);
      ev[EV_RSVD]      = 1'b0;
      ev[EV_TX_POP]    = tx_pop_ok;
      ev[EV_RX_PUSH]   = rx_push_ok;
      ev[EV_WF_POP]    = wf_pop_ok & tx_push_ok;
      ev[EV_PROTO]     = proto_rd_err;
      ev[EV_TX_AEMPTY] = tx_pop_ok & (tx_count <= aempty_q);
   end

   serbuf_irq #(.N(EVT_W)) irq_i (
      .clk(clk), .rst_n(rst_n),
      .set_v(ev), .clr_we(clr_we), .clr_v(clr_bits),
      .mask_we(mask_we), .mask_v(mask_bits),
      .status(irq_status), .mask(irq_mask), .irq(irq)
   );

   // flag word
   always_comb begin
      flags              = '0;
      flags[FL_RX_EMPTY] = rx_empty;
      flags[FL_WF_EMPTY] = wf_empty;
      flags[FL_TX_EMPTY] = tx_empty;
      flags[FL_RX_FULL]  = rx_full;
      flags[FL_WF_FULL]  = wf_full;
      flags[FL_TX_FULL]  = tx_full;
   end
endmodule

// File: rtl/serbuf_evt_chk.sv
module serbuf_evt_chk
   import serbuf_pkg::*;
#(
   parameter  int DATA_W   = 8,
   parameter  int RX_DEPTH = 256,
   parameter  int TX_DEPTH = 256,
   parameter  int WF_DEPTH = 4,
   localparam int RXC_W    = $clog2(RX_DEPTH + 1),
   localparam int TXC_W    = $clog2(TX_DEPTH + 1),
   localparam int WFC_W    = $clog2(WF_DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_push,
   input logic              host_rd,
   input logic              host_wr,
   input logic              tx_pop,
   input logic              clr_we,
   input logic [DATA_W-1:0] host_rd_data,
   input logic [RXC_W-1:0]  rx_count,
   input logic [TXC_W-1:0]  tx_count,
   input logic [WFC_W-1:0]  wf_count,
   input logic [FLAG_W-1:0] flags,
   input logic [EVT_W-1:0]  irq_status
);
   localparam logic [RXC_W-1:0] RX_MAX = RXC_W'(RX_DEPTH);
   localparam logic [TXC_W-1:0] TX_MAX = TXC_W'(TX_DEPTH);
   localparam logic [WFC_W-1:0] WF_MAX = WFC_W'(WF_DEPTH);

   a_r2_rx_bound: assert property (@(posedge clk) disable iff (!rst_n)
      rx_count <= RX_MAX);

   a_r3_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push && !host_rd && rx_count == RX_MAX) |=> (rx_count == RX_MAX && irq_status[EV_RX_OVF]));

   a_r5_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && rx_count == '0) |=> (host_rd_data == '0 && irq_status[EV_RD_EMPTY]));

   a_r6_wf_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && wf_count == WF_MAX) |=> irq_status[EV_WR_FULL]);

   a_r7_drain: assert property (@(posedge clk) disable iff (!rst_n)
      (wf_count != '0 && tx_count < TX_MAX && !tx_pop) |=> (tx_count == $past(tx_count) + 1'b1));

   a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_we |=> ((irq_status & $past(irq_status)) == $past(irq_status)));

   a_r13_flags: assert property (@(posedge clk) disable iff (!rst_n)
      !flags[0] && (flags[FL_RX_EMPTY] == (rx_count == '0)) && (flags[FL_WF_FULL] == (wf_count == WF_MAX)));

   a_r14_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_status[EV_RSVD]);
endmodule

bind serbuf_evt_unit serbuf_evt_chk #(
   .DATA_W(DATA_W), .RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH), .WF_DEPTH(WF_DEPTH)
) chk_i (
   .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .host_rd(host_rd),
   .host_wr(host_wr), .tx_pop(tx_pop), .clr_we(clr_we),
   .host_rd_data(host_rd_data), .rx_count(rx_count), .tx_count(tx_count),
   .wf_count(wf_count), .flags(flags), .irq_status(irq_status)
);

// File: tb/serbuf_evt_unit_tb_top.sv
`timescale 1ns/1ps
module serbuf_evt_unit_tb_top;
   localparam int RXD = 256;
   localparam int TXD = 256;
   localparam int WFD = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic       rx_push = 0, rx_frame_bad = 0, rx_parity_bad = 0, tx_pop = 0;
   logic [7:0] rx_data = 0, host_wr_data = 0;
   logic       host_rd = 0, host_wr = 0, proto_rd_err = 0;
   logic       clr_we = 0, mask_we = 0, thr_we = 0;
   logic [11:0] clr_bits = 0, mask_bits = 0;
   logic [8:0] thr_afull = 0, thr_aempty = 0;
   logic [7:0] tx_data, host_rd_data;
   logic       tx_valid, irq;
   logic [8:0] rx_count, tx_count;
   logic [2:0] wf_count;
   logic [6:0] flags;
   logic [11:0] irq_status, irq_mask;

   serbuf_evt_unit dut_i (
      .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_data(rx_data),
      .rx_frame_bad(rx_frame_bad), .rx_parity_bad(rx_parity_bad),
      .tx_pop(tx_pop), .tx_data(tx_data), .tx_valid(tx_valid),
      .host_rd(host_rd), .host_rd_data(host_rd_data),
      .host_wr(host_wr), .host_wr_data(host_wr_data),
      .proto_rd_err(proto_rd_err), .clr_we(clr_we), .clr_bits(clr_bits),
      .mask_we(mask_we), .mask_bits(mask_bits), .thr_we(thr_we),
      .thr_afull(thr_afull), .thr_aempty(thr_aempty),
      .rx_count(rx_count), .tx_count(tx_count), .wf_count(wf_count),
      .flags(flags), .irq_status(irq_status), .irq_mask(irq_mask), .irq(irq)
   );

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   logic [7:0] m_rx[$];
   logic [7:0] m_tx[$];
   logic [7:0] m_wf[$];
   logic [11:0] m_st = 0, m_mask = 0;
   logic [8:0] m_afull = 9'd192, m_aempty = 9'd8;
   logic [7:0] m_rd = 0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic string tag_of_bit(logic [11:0] diff);
      for (int i = 0; i < 12; i++) begin
         if (diff[i]) begin
            case (i)
               0: return "R5";
               1: return "R6";
               2, 3: return "R4";
               4: return "R3";
               5: return "R9";
               7: return "R8";
               8: return "R2";
               9: return "R7";
               11: return "R10";
               default: return "R14";
            endcase
         end
      end
      return "R11";
   endfunction

   function automatic logic [6:0] exp_flags();
      return {m_tx.size() == TXD, m_wf.size() == WFD, m_rx.size() == RXD,
              m_tx.size() == 0, m_wf.size() == 0, m_rx.size() == 0, 1'b0};
   endfunction

   // expected next state from the inputs present before the edge
   task automatic model_step();
      logic [11:0] set_v = '0;
      int n = m_rx.size();
      int t = m_tx.size();
      int w = m_wf.size();
      bit rd_pop = 0;
      bit rx_in = 0;
      if (host_rd) begin
         if (n == 0) begin set_v[0] = 1; m_rd = 0; end
         else begin m_rd = m_rx[0]; rd_pop = 1; end
      end
      if (rx_push) begin
         if (rx_frame_bad)  set_v[2] = 1;
         if (rx_parity_bad) set_v[3] = 1;
         if (n >= int'(m_afull)) set_v[5] = 1;
         if (n == RXD) set_v[4] = 1;
         else begin set_v[8] = 1; rx_in = 1; end
      end
      if (rd_pop) void'(m_rx.pop_front());
      if (rx_in) m_rx.push_back(rx_data);
      if (tx_pop && t > 0) begin
         set_v[7] = 1;
         if (t <= int'(m_aempty)) set_v[11] = 1;
         void'(m_tx.pop_front());
      end
      if (w > 0 && t < TXD) begin
         m_tx.push_back(m_wf[0]);
         void'(m_wf.pop_front());
         set_v[9] = 1;
      end
      if (host_wr) begin
         if (w == WFD) set_v[1] = 1;
         else m_wf.push_back(host_wr_data);
      end
      if (proto_rd_err) set_v[10] = 1;
      m_st = (m_st & ~(clr_we ? clr_bits : 12'h0)) | set_v;
      if (mask_we) m_mask = mask_bits;
      if (thr_we) begin m_afull = thr_afull; m_aempty = thr_aempty; end
   endtask

   task automatic compare_all();
      logic [11:0] d = irq_status ^ m_st;
      chk("R2", 32'(rx_count), 32'(m_rx.size()));
      chk("R7", 32'(tx_count), 32'(m_tx.size()));
      chk("R6", 32'(wf_count), 32'(m_wf.size()));
      chk("R13", 32'(flags), 32'(exp_flags()));
      chk(tag_of_bit(d), 32'(irq_status), 32'(m_st));
      chk("R12", 32'(irq_mask), 32'(m_mask));
      chk("R12", 32'(irq), 32'(|(m_st & ~m_mask)));
      chk("R2", 32'(host_rd_data), 32'(m_rd));
      chk("R7", 32'(tx_data), 32'(m_tx.size() == 0 ? 8'h0 : m_tx[0]));
      chk("R8", 32'(tx_valid), 32'(m_tx.size() != 0));
   endtask

   task automatic clear_inputs();
      rx_push = 0; rx_frame_bad = 0; rx_parity_bad = 0; tx_pop = 0;
      host_rd = 0; host_wr = 0; proto_rd_err = 0;
      clr_we = 0; mask_we = 0; thr_we = 0;
   endtask

   // inputs already set at a falling edge; advance one cycle and compare
   task automatic cycle();
      model_step();
      @(posedge clk);
      @(negedge clk);
      compare_all();
      clear_inputs();
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog actual hung expected finish");
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = $urandom(32'h5A17);
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", 32'(rx_count), 0);
      chk("R1", 32'(tx_count), 0);
      chk("R1", 32'(wf_count), 0);
      chk("R1", 32'(flags), 32'h0E);
      chk("R1", 32'(irq_status), 0);
      chk("R1", 32'(irq), 0);
      rst_n = 1;
      @(negedge clk);

      // R3 R4 R9: fill receive queue past its limit; thresholds left at reset values
      for (int i = 0; i < RXD + 4; i++) begin
         rx_push = 1; rx_data = 8'(i * 7 + 1);
         rx_frame_bad = (i == 3); rx_parity_bad = (i == 5);
         if (i == RXD + 1) host_rd = 1;
         cycle();
      end
      // R2 R5: drain past empty
      for (int i = 0; i < RXD + 3; i++) begin
         host_rd = 1; cycle();
      end
      clr_we = 1; clr_bits = 12'hFFF; cycle();

      // R11: clear and set on the same bit in one cycle
      rx_push = 1; rx_data = 8'hA5; clr_we = 1; clr_bits = 12'hFFF; cycle();
      host_rd = 1; cycle();

      // R6 R7: write every cycle with no pops until the staging queue overflows
      for (int i = 0; i < TXD + WFD + 6; i++) begin
         host_wr = 1; host_wr_data = 8'(i ^ 8'h3C); cycle();
      end
      // R8 R10: drain transmit queue, then pop while empty
      for (int i = 0; i < TXD + WFD + 4; i++) begin
         tx_pop = 1; cycle();
      end

      // R12: masked events keep recording
      mask_we = 1; mask_bits = 12'hFFF; cycle();
      proto_rd_err = 1; cycle();
      mask_we = 1; mask_bits = 12'h000; cycle();

      // seeded random phases with skewed rates
      for (int ph = 0; ph < 4; ph++) begin
         int p_rx = (ph == 0) ? 80 : (ph == 1) ? 30 : 55;
         int p_rd = (ph == 0) ? 20 : (ph == 1) ? 70 : 50;
         int p_wr = (ph == 2) ? 90 : 50;
         int p_tx = (ph == 2) ? 20 : (ph == 3) ? 60 : 45;
         for (int c = 0; c < 1000; c++) begin
            rx_push = ($urandom % 100) < p_rx;
            rx_data = 8'($urandom);
            rx_frame_bad = ($urandom % 8) == 0;
            rx_parity_bad = ($urandom % 8) == 0;
            host_rd = ($urandom % 100) < p_rd;
            host_wr = ($urandom % 100) < p_wr;
            host_wr_data = 8'($urandom);
            tx_pop = ($urandom % 100) < p_tx;
            proto_rd_err = ($urandom % 16) == 0;
            clr_we = ($urandom % 6) == 0;
            clr_bits = 12'($urandom);
            mask_we = ($urandom % 40) == 0;
            mask_bits = 12'($urandom);
            thr_we = ($urandom % 60) == 0;
            thr_afull = 9'($urandom % 257);
            thr_aempty = 9'($urandom % 257);
            cycle();
         end
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule